// File: doc/BRIEF.md
# Clock root slice controller

This block produces one root clock from four free-running source clocks. Software writes a control word with three fields: a source select, an integer divider and an off bit. The block switches between sources without glitches, divides the selected clock, and gates the result. A status word reports a busy flag while a newly written setting is still on its way to the output clock. Software writes the control word and then polls busy until it clears, which tells it that the new frequency or gate state is live.

A control write that alters any field starts a reconfiguration. The register side holds a copy of the setting that was last launched. It sends a toggle request to the output-clock side and waits for a toggle acknowledge, passed back through a two-flop synchronizer. Busy stays set while a request is in flight or while the control word differs from the launched copy. If several writes land during one reconfiguration, the last one is launched next, and busy does not drop between the two.

Top module: `clk_root_slice`

## Requirements
- R1: After reset the control word reads 0x0000_0000, the status word reads 0, and the output runs from source 0 undivided.
- R2: The control word is at byte offset 0x0. The divider is in bits [7:0], the source select in bits [9:8] and the off bit in bit 24. All other bits read 0, and writing them has no effect.
- R3: The status word is at byte offset 0x4. Busy is bit 28 and every other bit reads 0. Writes to offset 0x4 change nothing.
- R4: A control write that changes the divider, the source or the off bit makes busy read 1 in the bus cycle after the write.
- R5: A control write that leaves all three fields unchanged, made while the block is idle, leaves busy at 0.
- R6: Busy clears within 2000 bus clock cycles (40 us at 50 MHz), well inside the 500 us that software allows.
- R7: Once busy has cleared, the output period equals the selected source period times (divider + 1). A divider of 0 passes the source clock through.
- R8: Source select value n routes source n. A source change never puts a high or low phase on the output that is shorter than half the period of the fastest source.
- R9: With the off bit at 1, the output stays low once busy has cleared. Writing the off bit back to 0 restarts the output.
- R10: A new divider value takes effect only at a boundary of the divided period, so a divider change also produces no short output phase.
- R11: When the control word is rewritten during a reconfiguration, busy stays set until the last value written is live on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | 4 | Source clocks, index equals select value |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| clk_out | output | 1 | Gated, divided root clock |

## Verification
The bench attacks source switches between clocks of unrelated periods, divider changes in and out of pass-through, and gating off and on. A global phase monitor catches any runt pulse. A switch that overlaps two sources, or a divider applied mid-period, would show up there as a phase shorter than 7 ns. Back-to-back writes check that busy does not drop between two reconfigurations, and that the second setting is the one that appears. A block that acknowledged early would show the wrong period after busy cleared. Identical rewrites and writes to the status offset must leave busy low and the control word unchanged; a change detector that fired on every write would fail here.

// File: rtl/crs_pkg.sv
package crs_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int DIV_W   = 8;
  localparam int SEL_W   = 2;
  localparam int NSRC    = 1 << SEL_W;
  localparam int DIV_LSB = 0;
  localparam int SEL_LSB = 8;
  localparam int OFF_POS = 24;
  localparam int BUSY_POS = 28;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(4);

  typedef struct packed {
    logic             off;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
  } slice_cfg_t;
endpackage

// File: rtl/crs_rst_sync.sv
module crs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  assign stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign rst_n = stage_q[1];
endmodule

// File: rtl/crs_regs.sv
module crs_regs
  import crs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ack_tog,
  output slice_cfg_t        live_cfg,
  output logic              req_tog,
  output logic              busy
);
  slice_cfg_t ctrl_q, ctrl_d, live_q, live_d, wr_cfg;
  logic inflight_q, inflight_d, req_q, req_d;
  logic ack_s1, ack_s2;
  logic ctrl_we, stat_we, dirty, launch, ack_done;
  logic unused_wbits;

  assign unused_wbits = ^bus_wdata;
  assign ctrl_we  = bus_en & bus_wr & (bus_addr == CTRL_ADDR);
  assign stat_we  = bus_en & bus_wr & (bus_addr == STAT_ADDR);
  assign wr_cfg.div = bus_wdata[DIV_LSB +: DIV_W];
  assign wr_cfg.sel = bus_wdata[SEL_LSB +: SEL_W];
  assign wr_cfg.off = bus_wdata[OFF_POS];
  assign dirty    = (ctrl_q != live_q);
  assign launch   = dirty & ~inflight_q;
  assign ack_done = inflight_q & (ack_s2 == req_q);

  always_comb begin
    ctrl_d     = ctrl_we ? wr_cfg : ctrl_q;
    live_d     = launch ? ctrl_q : live_q;
    req_d      = launch ? ~req_q : req_q;
    inflight_d = launch | (inflight_q & ~ack_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      live_q     <= '0;
      req_q      <= 1'b0;
      inflight_q <= 1'b0;
      ack_s1     <= 1'b0;
      ack_s2     <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      live_q     <= live_d;
      req_q      <= req_d;
      inflight_q <= inflight_d;
      ack_s1     <= ack_tog;
      ack_s2     <= ack_s1;
    end
  end

  assign busy     = inflight_q | dirty;
  assign live_cfg = live_q;
  assign req_tog  = req_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_ADDR) begin
      bus_rdata[DIV_LSB +: DIV_W] = ctrl_q.div;
      bus_rdata[SEL_LSB +: SEL_W] = ctrl_q.sel;
      bus_rdata[OFF_POS]          = ctrl_q.off;
    end else if (bus_addr == STAT_ADDR) begin
      bus_rdata[BUSY_POS] = busy;
    end
  end

  // R4
  busy_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && (wr_cfg != ctrl_q)) |=> busy);
  // R11
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight_q && !ack_done) |=> $stable(live_q));
  // R3
  stat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> $stable(ctrl_q));
endmodule

// File: rtl/crs_src_switch.sv
module crs_src_switch #(
  parameter int SEL_W = 2,
  localparam int NSRC = 1 << SEL_W
) (
  input  logic [NSRC-1:0]  src_clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             mclk,
  output logic [NSRC-1:0]  live
);
  logic [NSRC-1:0] en_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic want, s1_q, s2_q, en_n_q;
    assign want = (sel == SEL_W'(i)) & ~|(en_q & ~(NSRC'(1) << i));

    always_ff @(posedge src_clk[i] or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= want;
        s2_q <= s1_q;
      end
    end

    always_ff @(negedge src_clk[i] or negedge rst_n) begin
      if (!rst_n) en_n_q <= 1'b0;
      else        en_n_q <= s2_q;
    end

    assign en_q[i] = en_n_q;
  end

  assign mclk = |(src_clk & en_q);
  assign live = en_q;

  always_comb begin
    if (rst_n) begin
      // R8
      src_mutex_chk: assert ($onehot0(en_q));
    end
  end
endmodule

// File: rtl/crs_divider.sv
module crs_divider #(
  parameter int DIV_W = 8,
  localparam int CW = DIV_W + 1
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             sel_live,
  input  logic             req_tog,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_off,
  output logic             ack_tog,
  output logic             clk_out
);
  logic [DIV_W-1:0] cnt_q, cnt_d, div_q, div_d;
  logic [CW-1:0]    half_d;
  logic off_q, off_d, ack_q, ack_d, hi_q, hi_d, pt_q, pt_d;
  logic req_s1, req_s2, boundary, apply;

  assign boundary = (cnt_q == div_q);
  assign apply    = (req_s2 != ack_q) & sel_live & boundary;

  always_comb begin
    div_d = div_q;
    off_d = off_q;
    ack_d = ack_q;
    if (apply) begin
      div_d = cfg_div;
      off_d = cfg_off;
      ack_d = req_s2;
    end
    cnt_d  = boundary ? '0 : cnt_q + 1'b1;
    half_d = ({1'b0, div_d} + CW'(2)) >> 1;
    hi_d   = ~off_d & (div_d != '0) & ({1'b0, cnt_d} < half_d);
    pt_d   = ~off_q & (div_q == '0);
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      div_q  <= '0;
      off_q  <= 1'b0;
      ack_q  <= 1'b0;
      hi_q   <= 1'b0;
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      div_q  <= div_d;
      off_q  <= off_d;
      ack_q  <= ack_d;
      hi_q   <= hi_d;
      req_s1 <= req_tog;
      req_s2 <= req_s1;
    end
  end

  always_ff @(negedge mclk or negedge rst_n) begin
    if (!rst_n) pt_q <= 1'b0;
    else        pt_q <= pt_d;
  end

  assign clk_out = (mclk & pt_q) | hi_q;
  assign ack_tog = ack_q;

  // R9
  off_low_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    (off_q && !apply) |=> !hi_q);
  // R7
  div_rise_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    (!apply && boundary && !off_q && (div_q != '0)) |=> hi_q);
endmodule

// File: rtl/clk_root_slice.sv
module clk_root_slice
  import crs_pkg::*;
(
  input  logic              bus_clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_clk,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              clk_out
);
  slice_cfg_t      live_cfg;
  logic            bus_rst_n, m_rst_n, mclk;
  logic            req_tog, ack_tog, busy;
  logic [NSRC-1:0] live_vec;
  logic            sel_live;

  crs_rst_sync u_bus_rst (.clk(bus_clk), .arst_n(rst_n), .rst_n(bus_rst_n));
  crs_rst_sync u_m_rst   (.clk(mclk),    .arst_n(rst_n), .rst_n(m_rst_n));

  crs_regs u_regs (
    .clk(bus_clk), .rst_n(bus_rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack_tog(ack_tog), .live_cfg(live_cfg), .req_tog(req_tog), .busy(busy)
  );

  crs_src_switch #(.SEL_W(SEL_W)) u_switch (
    .src_clk(src_clk), .rst_n(rst_n), .sel(live_cfg.sel),
    .mclk(mclk), .live(live_vec)
  );

  assign sel_live = live_vec[live_cfg.sel];

  crs_divider #(.DIV_W(DIV_W)) u_div (
    .mclk(mclk), .rst_n(m_rst_n), .sel_live(sel_live), .req_tog(req_tog),
    .cfg_div(live_cfg.div), .cfg_off(live_cfg.off),
    .ack_tog(ack_tog), .clk_out(clk_out)
  );
endmodule

// File: tb/clk_root_slice_test.sv
`timescale 1ns/1ps
module clk_root_slice_test;
  localparam int LIMIT = 2000;
  localparam logic [31:0] FMASK = 32'h0100_03FF;
  localparam logic [31:0] BUSYW = 32'h1000_0000;

  logic bus_clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] src_clk = 4'b0;
  logic bus_en = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'h4;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic clk_out;

  real src_per [4] = '{14.0, 22.0, 34.0, 46.0};
  logic [31:0] m_ctrl = '0;
  int exp_busy = 0;
  string busy_tag = "R1 status after reset";
  int n_chk = 0, n_fail = 0, n_edges = 0;
  bit done = 1'b0, armed = 1'b0, seen = 1'b0;
  realtime last_t = 0.0;

  clk_root_slice uut (
    .bus_clk(bus_clk), .rst_n(rst_n), .src_clk(src_clk), .bus_en(bus_en),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .clk_out(clk_out)
  );

  always #10 bus_clk = ~bus_clk;
  initial forever #7 src_clk[0] = ~src_clk[0];
  initial begin #3; forever #11 src_clk[1] = ~src_clk[1]; end
  initial begin #5; forever #17 src_clk[2] = ~src_clk[2]; end
  initial begin #2; forever #23 src_clk[3] = ~src_clk[3]; end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference model comparison on every bus clock
  always @(negedge bus_clk) begin
    if (rst_n && !done) begin
      if (bus_addr == 4'h0)
        chk(bus_rdata == m_ctrl, "R2 control readback", bus_rdata, m_ctrl);
      else if (bus_addr == 4'h4 && exp_busy >= 0)
        chk(bus_rdata == (exp_busy != 0 ? BUSYW : 32'h0), busy_tag, bus_rdata,
            (exp_busy != 0 ? BUSYW : 32'h0));
    end
  end

  // R8 R10: no runt phase on the output
  always @(clk_out) begin
    if (armed && !done) begin
      if (seen)
        chk(($realtime - last_t) >= 6.5, "R8 R10 min phase", $rtoi(($realtime - last_t) * 1000.0), 32'd7000);
      seen = 1'b1;
    end
    last_t = $realtime;
  end

  always @(posedge clk_out) n_edges++;

  task automatic wr(input logic [3:0] addr, input logic [31:0] data);
    logic [31:0] nv;
    @(posedge bus_clk); #1;
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
    @(posedge bus_clk); #1;
    bus_en = 1'b0; bus_wr = 1'b0; bus_addr = 4'h4;
    nv = data & FMASK;
    if (addr == 4'h0 && nv != m_ctrl) begin
      m_ctrl = nv;
      exp_busy = 1;
      busy_tag = "R4 busy after change";
      @(posedge bus_clk); #1;
      exp_busy = -1;
    end else begin
      busy_tag = (addr == 4'h0) ? "R5 busy on identical write" : "R3 status write ignored";
    end
  endtask

  task automatic settle(input string tag);
    int cyc = 0;
    bus_addr = 4'h4;
    forever begin
      @(negedge bus_clk);
      if (!bus_rdata[28] || cyc > LIMIT) break;
      cyc++;
    end
    chk(cyc <= LIMIT, tag, cyc, LIMIT);
    busy_tag = "R11 busy stays low once idle";
    exp_busy = 0;
  endtask

  task automatic read_ctrl();
    @(posedge bus_clk); #1 bus_addr = 4'h0;
    @(posedge bus_clk); #1 bus_addr = 4'h4;
  endtask

  task automatic measure(input int sel, input int div, input string tag);
    realtime t0, per, expv;
    expv = src_per[sel] * (div + 1);
    repeat (3) @(posedge clk_out);
    t0 = $realtime;
    repeat (4) @(posedge clk_out);
    per = ($realtime - t0) / 4.0;
    chk((per - expv) < 0.05 && (expv - per) < 0.05, tag, $rtoi(per * 1000.0), $rtoi(expv * 1000.0));
  endtask

  task automatic expect_silent(input string tag);
    int e0;
    repeat (4) @(posedge bus_clk);
    e0 = n_edges;
    repeat (80) @(posedge bus_clk);
    chk(n_edges == e0 && clk_out == 1'b0, tag, n_edges - e0, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(150000 * 20);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL R6 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    #205 rst_n = 1'b1;
    repeat (4) @(posedge bus_clk);
    #1 bus_addr = 4'h4;
    @(negedge bus_clk);
    chk(bus_rdata == 32'h0, "R1 status reset", bus_rdata, 32'h0);
    #1 bus_addr = 4'h0;
    @(negedge bus_clk);
    chk(bus_rdata == 32'h0, "R1 control reset", bus_rdata, 32'h0);
    #1 bus_addr = 4'h4;
    armed = 1'b1;
    measure(0, 0, "R1 reset output passes source 0");

    // R2: every bit written, only the fields stick; R9 off
    wr(4'h0, 32'hFFFF_FFFF);
    read_ctrl();
    settle("R6 busy clear after all-ones write");
    expect_silent("R9 off holds output low");

    // R7 R8: source 1, divide by 4
    wr(4'h0, 32'h0000_0103);
    settle("R6 busy clear source 1");
    measure(1, 3, "R7 source 1 div 4");

    // R5: identical rewrite
    wr(4'h0, 32'h0000_0103);
    repeat (10) @(posedge bus_clk);
    chk(bus_rdata == 32'h0, "R5 no busy after identical write", bus_rdata, 32'h0);

    // R3: status write ignored
    wr(4'h4, 32'hFFFF_FFFF);
    read_ctrl();
    repeat (5) @(posedge bus_clk);
    chk(bus_rdata == 32'h0, "R3 status unaffected", bus_rdata, 32'h0);

    // R7 pass-through of source 2
    wr(4'h0, 32'h0000_0200);
    settle("R6 busy clear source 2");
    measure(2, 0, "R7 source 2 pass-through");

    // R8 source 3, odd divider
    wr(4'h0, 32'h0000_0302);
    settle("R6 busy clear source 3");
    measure(3, 2, "R8 source 3 div 3");

    // R11 back-to-back writes
    wr(4'h0, 32'h0000_0004);
    wr(4'h0, 32'h0000_0201);
    read_ctrl();
    settle("R11 busy clear after second write");
    measure(2, 1, "R11 last write is live");

    // R9 gate off then on
    wr(4'h0, 32'h0100_0201);
    settle("R6 busy clear gate off");
    expect_silent("R9 gate off at divide by 2");
    wr(4'h0, 32'h0000_0201);
    settle("R6 busy clear gate on");
    measure(2, 1, "R9 output restarts");

    // R10 divider changes on one source
    wr(4'h0, 32'h0000_0005);
    settle("R6 busy clear div 6");
    measure(0, 5, "R10 source 0 div 6");
    wr(4'h0, 32'h0000_0000);
    settle("R6 busy clear div 1");
    measure(0, 0, "R10 back to pass-through");

    repeat (5) @(posedge bus_clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule